// File: doc/BRIEF.md
# Dual-mode 8-bit PWM timer

This block is an 8-bit timer/counter that produces one pulse-width-modulated output. It advances only on cycles where an external prescaler asserts a one-cycle tick, so the PWM rate is the clock rate divided by the prescale factor and by the counter period. The prescale factor is typically 1, 8, 32, 64, 128, 256 or 1024. A waveform-mode bit selects the counter shape. In the wrapping (single-slope) mode the counter climbs from 0 to 255 and then restarts at 0. In the up-down (dual-slope) mode it climbs to 255 and then falls back to 0, which gives a symmetric, centre-aligned waveform.

A small write interface sets the waveform mode and a 2-bit output mode in one write, and writes a compare value separately. The compare value goes into a shadow register. It reaches the comparator only at a fixed point in the count, so a value written mid-period never produces a torn pulse. Two sticky flags record the counter reaching its end-of-period value and the count meeting the compare value. Each flag is cleared by writing a one to its clear bit.

Top module: `pwm8_dual_timer`

## Requirements
- R1: After a synchronous reset the output and both flags are 0, the counter is at 0 counting up, the mode is wrapping with output off, and both compare registers hold 0.
- R2: In wrapping mode (cfg_dual=0) each tick advances the count by one, and a tick at 255 returns it to 0. The overflow flag sets on the tick that brings the count to 255.
- R3: In wrapping mode with output mode 2 (non-inverting), the output after each tick is 1 exactly when the new count is less than or equal to the active compare value k. That gives k+1 high ticks per 256-tick period: a one-tick spike for k=0 and a constant 1 for k=255. Output mode 3 gives the complement.
- R4: In wrapping mode with output mode 1, the output inverts on every tick whose new count equals the active compare value. The result is a 50% square wave with a period of 512 ticks.
- R5: In up-down mode (cfg_dual=1) the count runs 0,1,…,255,254,…,1 and repeats. Each value lasts one tick, 255 and 0 appear once, and the period is 510 ticks. The overflow flag sets on the tick that brings the count to 0.
- R6: In up-down mode with output mode 2, the output after each tick is 1 exactly when the new count is less than the active compare value k. That gives 2k-1 high ticks per 510-tick period for k≥1 and none for k=0. Output mode 3 gives the complement.
- R7: Output mode 0 in either counter mode, and output mode 1 in up-down mode, hold the output at 0.
- R8: A compare write goes into the shadow register only. The active value takes the shadow value on the tick that moves the count off 255, in both modes. A compare write in that same cycle is taken directly.
- R9: The match flag sets on every tick whose new count equals the active compare value, and it stays set.
- R10: flag_clr bit 0 clears the overflow flag and bit 1 clears the match flag. If a flag sets in the same cycle as its clear, the set wins.
- R11: A configuration write (cfg_we=1) restarts the count at 0 counting up, forces the output to 0, and loads the active compare value from the shadow, or from cmp_wdata if cmp_we is also high. It takes precedence over a tick in the same cycle and does not set any flag.
- R12: In a cycle with tick=0 and cfg_we=0, the count, the output and the active compare value do not change.
- R13: All outputs are registers. They change at the clock edge that samples the tick, write or clear causing the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from the prescaler, one cycle wide |
| cfg_we | input | 1 | Write strobe for waveform mode and output mode; restarts the counter |
| cfg_dual | input | 1 | Waveform mode: 0 wrapping, 1 up-down |
| cfg_out | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverting, 3 inverting |
| cmp_we | input | 1 | Write strobe for the compare shadow register |
| cmp_wdata | input | 8 | Compare value to write |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 match |
| pwm_o | output | 1 | PWM output |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
Every result of this block appears one edge after the cycle that causes it: the new output level, the flag sets and clears, and the restart after a configuration write. A compare write is the exception. It reaches the output only after the next tick that leaves 255, so its effect can come up to a full period later. The driver applies stimulus at the falling edge and pushes the values the requirements predict for the following rising edge. The monitor pops that item just after the rising edge, which keeps every comparison on exactly the edge that is due. The duty-cycle counts per period are taken only after two full periods have passed since the restart that loaded the compare value, so the count covers a whole steady cycle.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;
endpackage

// File: rtl/pwm_slope_counter.sv
// Counter that either wraps at the top or reverses direction at both ends.
module pwm_slope_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         tick,
  input  logic         dual,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         step,
  output logic         at_top
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = {W{1'b0}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic up_q, up_nxt;

  assign step   = tick & ~restart;
  assign at_top = step & (cnt_q == TOP);

  always_comb begin
    cnt_nxt = cnt_q;
    up_nxt  = up_q;
    if (restart) begin
      cnt_nxt = BOT;
      up_nxt  = 1'b1;
    end else if (tick) begin
      if (!dual) begin
        cnt_nxt = (cnt_q == TOP) ? BOT : cnt_q + ONE;
        up_nxt  = 1'b1;
      end else if (up_q) begin
        if (cnt_q == TOP) begin
          cnt_nxt = TOP - ONE;
          up_nxt  = 1'b0;
        end else begin
          cnt_nxt = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == BOT) begin
          cnt_nxt = BOT + ONE;
          up_nxt  = 1'b1;
        end else begin
          cnt_nxt = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= BOT;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
    end
  end
endmodule

// File: rtl/pwm_cmp_shadow.sv
// Shadow and active compare registers; the active copy loads only on request.
module pwm_cmp_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] act_q,
  output logic [W-1:0] act_nxt
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] src;

  assign src     = wr_en ? wr_data : shadow_q;
  assign act_nxt = load ? src : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= src;
      act_q    <= act_nxt;
    end
  end
endmodule

// File: rtl/pwm_wave_gen.sv
// Output register: level compare of the next count, or toggle on equality.
module pwm_wave_gen #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                step,
  input  logic                dual,
  input  pwm8_pkg::out_mode_e omode,
  input  logic [W-1:0]        cnt_nxt,
  input  logic [W-1:0]        ocr_nxt,
  output logic                pwm_q
);
  import pwm8_pkg::*;

  logic lvl_wrap, lvl_updn, hit, pwm_nxt;

  assign lvl_wrap = (cnt_nxt <= ocr_nxt);
  assign lvl_updn = (cnt_nxt <  ocr_nxt);
  assign hit      = (cnt_nxt == ocr_nxt);

  always_comb begin
    pwm_nxt = pwm_q;
    if (restart) begin
      pwm_nxt = 1'b0;
    end else if (step) begin
      case (omode)
        OUT_OFF:    pwm_nxt = 1'b0;
        OUT_TOGGLE: pwm_nxt = dual ? 1'b0 : (pwm_q ^ hit);
        OUT_NONINV: pwm_nxt = dual ? lvl_updn : lvl_wrap;
        OUT_INV:    pwm_nxt = dual ? ~lvl_updn : ~lvl_wrap;
        default:    pwm_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_nxt;
  end
endmodule

// File: rtl/pwm_flags.sv
// Sticky overflow and match flags with write-one-to-clear; set wins.
module pwm_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         dual,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] ocr_nxt,
  input  logic [1:0]   clr,
  output logic         ovf_q,
  output logic         mat_q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = {W{1'b0}};

  logic ovf_set, mat_set;

  assign ovf_set = step & (dual ? (cnt_nxt == BOT) : (cnt_nxt == TOP));
  assign mat_set = step & (cnt_nxt == ocr_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      mat_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set | (ovf_q & ~clr[0]);
      mat_q <= mat_set | (mat_q & ~clr[1]);
    end
  end
endmodule

// File: rtl/pwm8_dual_timer.sv
module pwm8_dual_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic             cfg_dual,
  input  logic [1:0]       cfg_out,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [1:0]       flag_clr,
  output logic             pwm_o,
  output logic             ovf_flag,
  output logic             match_flag
);
  import pwm8_pkg::*;

  logic             dual_q;
  out_mode_e        omode_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] ocr_act, ocr_nxt;
  logic             step, at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      dual_q  <= 1'b0;
      omode_q <= OUT_OFF;
    end else if (cfg_we) begin
      dual_q  <= cfg_dual;
      omode_q <= out_mode_e'(cfg_out);
    end
  end

  pwm_slope_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(cfg_we), .tick(tick), .dual(dual_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .step(step), .at_top(at_top)
  );

  pwm_cmp_shadow #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(cmp_we), .wr_data(cmp_wdata),
    .load(at_top | cfg_we), .act_q(ocr_act), .act_nxt(ocr_nxt)
  );

  pwm_wave_gen #(.W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .restart(cfg_we), .step(step), .dual(dual_q),
    .omode(omode_q), .cnt_nxt(cnt_nxt), .ocr_nxt(ocr_nxt), .pwm_q(pwm_o)
  );

  pwm_flags #(.W(CNT_W)) u_flags (
    .clk(clk), .rst(rst), .step(step), .dual(dual_q), .cnt_nxt(cnt_nxt),
    .ocr_nxt(ocr_nxt), .clr(flag_clr), .ovf_q(ovf_flag), .mat_q(match_flag)
  );
endmodule

// File: rtl/pwm8_dual_timer_chk.sv
module pwm8_dual_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         cfg_we,
  input logic [1:0]   flag_clr,
  input logic         pwm_o,
  input logic         ovf_flag,
  input logic         match_flag,
  input logic [W-1:0] cnt,
  input logic         dual,
  input logic [1:0]   omode,
  input logic [W-1:0] ocr_act
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && tick && !dual && cnt == TOP) |=> (cnt == '0)); // R2
  AST_UPDN_TURN: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && tick && dual && cnt == TOP) |=> (cnt == TOP - ONE)); // R5
  AST_OUT_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (omode == 2'd0 || (dual && omode == 2'd1)) |-> !pwm_o); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !(tick && cnt == TOP)) |=> $stable(ocr_act)); // R8
  AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (match_flag && !flag_clr[1]) |=> match_flag); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr[0]) |=> ovf_flag); // R10
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cnt == '0 && !pwm_o)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cfg_we) |=> ($stable(pwm_o) && $stable(cnt))); // R12
endmodule

bind pwm8_dual_timer pwm8_dual_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .flag_clr(flag_clr),
  .pwm_o(pwm_o), .ovf_flag(ovf_flag), .match_flag(match_flag),
  .cnt(cnt_q), .dual(dual_q), .omode(omode_q), .ocr_act(ocr_act)
);

// File: tb/tb_pwm8_dual_timer.sv
`timescale 1ns/1ps
module tb_pwm8_dual_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, cfg_we = 1'b0, cfg_dual = 1'b0, cmp_we = 1'b0;
  logic [1:0] cfg_out = 2'd0, flag_clr = 2'd0;
  logic [7:0] cmp_wdata = 8'd0;
  logic       pwm_o, ovf_flag, match_flag;

  always #2.5 clk = ~clk;

  pwm8_dual_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_dual(cfg_dual),
    .cfg_out(cfg_out), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .flag_clr(flag_clr), .pwm_o(pwm_o), .ovf_flag(ovf_flag),
    .match_flag(match_flag)
  );

  typedef struct {
    logic  pwm;
    logic  ovf;
    logic  mat;
    bit    win;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0, errors = 0, hi_cnt = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // reference state, built from the requirements
  logic [7:0] m_cnt = 0, m_act = 0, m_buf = 0;
  logic       m_up = 1, m_dual = 0, m_pwm = 0, m_ovf = 0, m_mat = 0;
  logic [1:0] m_om = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus at the falling edge, push the
  // values due at the next rising edge (R13)
  task automatic cyc(input logic t, input logic cw, input logic cd,
                     input logic [1:0] co, input logic mw,
                     input logic [7:0] md, input logic [1:0] cl,
                     input bit win);
    exp_t e;
    logic [7:0] nc, na;
    logic nu, np;
    @(negedge clk);
    tick = t; cfg_we = cw; cfg_dual = cd; cfg_out = co;
    cmp_we = mw; cmp_wdata = md; flag_clr = cl;
    if (cw) begin
      m_dual = cd; m_om = co; m_cnt = 0; m_up = 1; m_pwm = 0;
      m_act = mw ? md : m_buf;
      m_ovf = m_ovf & ~cl[0];
      m_mat = m_mat & ~cl[1];
    end else begin
      nc = m_cnt; nu = m_up; na = m_act; np = m_pwm;
      if (t) begin
        if (!m_dual) begin
          nc = (m_cnt == 8'd255) ? 8'd0 : m_cnt + 8'd1; nu = 1;
        end else if (m_up) begin
          if (m_cnt == 8'd255) begin nc = 8'd254; nu = 0; end
          else nc = m_cnt + 8'd1;
        end else begin
          if (m_cnt == 8'd0) begin nc = 8'd1; nu = 1; end
          else nc = m_cnt - 8'd1;
        end
        if (m_cnt == 8'd255) na = mw ? md : m_buf;
        case (m_om)
          2'd0: np = 0;
          2'd1: np = m_dual ? 1'b0 : ((nc == na) ? ~m_pwm : m_pwm);
          2'd2: np = m_dual ? (nc < na) : (nc <= na);
          default: np = m_dual ? !(nc < na) : !(nc <= na);
        endcase
      end
      m_ovf = (m_ovf & ~cl[0]) | (t & (m_dual ? (nc == 8'd0) : (nc == 8'd255)));
      m_mat = (m_mat & ~cl[1]) | (t & (nc == na));
      m_cnt = nc; m_up = nu; m_act = na; m_pwm = np;
    end
    if (mw) m_buf = md;
    e.pwm = m_pwm; e.ovf = m_ovf; e.mat = m_mat; e.win = win; e.tag = cur_tag;
    sb.push_back(e);
  endtask

  task automatic run(input int n, input bit win);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 2'd0, 0, 8'd0, 2'd0, win);
  endtask

  task automatic drain();
    @(posedge clk); #2;
  endtask

  // load mode and compare value, settle two periods, count one window
  task automatic duty_case(input logic dual, input logic [1:0] om,
                           input logic [7:0] k, input int exp_hi,
                           input string tag);
    int per, win;
    per = dual ? 510 : 256;
    win = (om == 2'd1 && !dual) ? 512 : per;
    cur_tag = tag;
    cyc(0, 1, dual, om, 1, k, 2'b11, 0);
    run(2 * per, 0);
    hi_cnt = 0;
    run(win, 1);
    drain();
    check(hi_cnt == exp_hi, tag, $sformatf("high ticks k=%0d", k), hi_cnt, exp_hi);
  endtask

  // monitor: pops the item due at this rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(pwm_o == e.pwm, e.tag, "pwm_o", pwm_o, e.pwm);
        check(ovf_flag == e.ovf, "R2/R5/R10 ovf", e.tag == "" ? "" : e.tag, ovf_flag, e.ovf);
        check(match_flag == e.mat, "R9/R10 match", e.tag, match_flag, e.mat);
        if (e.win && pwm_o) hi_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog expired actual=150000 expected<150000");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(pwm_o == 0 && ovf_flag == 0 && match_flag == 0, "R1", "outputs after reset",
          {pwm_o, ovf_flag, match_flag}, 0);

    // R1: from reset the output is off; ticks keep it low (R7)
    cur_tag = "R1/R7";
    run(300, 0);

    // R3: wrapping non-inverting sweep
    duty_case(0, 2'd2, 8'd0,   1,   "R3");
    duty_case(0, 2'd2, 8'd1,   2,   "R3");
    duty_case(0, 2'd2, 8'd128, 129, "R3");
    duty_case(0, 2'd2, 8'd254, 255, "R3");
    duty_case(0, 2'd2, 8'd255, 256, "R3");
    duty_case(0, 2'd3, 8'd128, 127, "R3 inverted");
    // R4: toggle square wave
    duty_case(0, 2'd1, 8'd0,   256, "R4");
    // R6: up-down non-inverting sweep (R5 sequence checked per cycle)
    duty_case(1, 2'd2, 8'd0,   0,   "R5/R6");
    duty_case(1, 2'd2, 8'd1,   1,   "R5/R6");
    duty_case(1, 2'd2, 8'd128, 255, "R5/R6");
    duty_case(1, 2'd2, 8'd254, 507, "R5/R6");
    duty_case(1, 2'd2, 8'd255, 509, "R5/R6");
    duty_case(1, 2'd3, 8'd1,   509, "R6 inverted");
    // R7: off and up-down toggle stay low
    duty_case(0, 2'd0, 8'd128, 0,   "R7");
    duty_case(1, 2'd1, 8'd5,   0,   "R7");

    // R8: shadow write mid-period, then a write on the load tick
    cur_tag = "R8";
    cyc(0, 1, 0, 2'd2, 1, 8'd10, 2'b11, 0);
    run(100, 0);
    cyc(1, 0, 0, 2'd0, 1, 8'd200, 2'd0, 0);
    run(400, 0);
    while (m_cnt != 8'd255) cyc(1, 0, 0, 2'd0, 0, 8'd0, 2'd0, 0);
    cyc(1, 0, 0, 2'd0, 1, 8'd40, 2'd0, 0);
    run(300, 0);
    cyc(0, 1, 1, 2'd2, 0, 8'd0, 2'd0, 0);
    run(200, 0);
    cyc(1, 0, 0, 2'd0, 1, 8'd90, 2'd0, 0);
    run(900, 0);

    // R10: clears, and set winning over a same-cycle clear
    cur_tag = "R10";
    cyc(0, 1, 0, 2'd2, 1, 8'd50, 2'd0, 0);
    run(300, 0);
    cyc(0, 0, 0, 2'd0, 0, 8'd0, 2'b11, 0);
    while (m_cnt != 8'd254) cyc(1, 0, 0, 2'd0, 0, 8'd0, 2'd0, 0);
    cyc(1, 0, 0, 2'd0, 0, 8'd0, 2'b01, 0);
    while (m_cnt != 8'd49) cyc(1, 0, 0, 2'd0, 0, 8'd0, 2'd0, 0);
    cyc(1, 0, 0, 2'd0, 0, 8'd0, 2'b10, 0);
    cyc(1, 0, 0, 2'd0, 0, 8'd0, 2'b11, 0);

    // R12: sparse ticks in both modes
    cur_tag = "R12";
    for (int i = 0; i < 1200; i++)
      cyc((i % 3) != 0, 0, 0, 2'd0, 0, 8'd0, 2'd0, 0);
    cyc(0, 1, 1, 2'd3, 1, 8'd77, 2'd0, 0);
    for (int i = 0; i < 1600; i++)
      cyc((i % 4) == 1, 0, 0, 2'd0, 0, 8'd0, 2'd0, 0);

    // R11: configuration write coinciding with a tick
    cur_tag = "R11";
    run(123, 0);
    cyc(1, 1, 0, 2'd2, 0, 8'd0, 2'd0, 0);
    run(300, 0);
    cyc(1, 1, 1, 2'd2, 1, 8'd33, 2'd0, 0);
    run(600, 0);
    drain();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule